// File: doc/BRIEF.md
# Pulse-Width Single-Wire Shift Receiver

This block takes serial data from one wire that carries both the data and its timing. The wire rests high. Each bit is sent as a low pulse, and the pulse ends with a rising edge. When that rising edge arrives, the block measures how long the line was low, in system clocks. A short low means a 1 and a long low means a 0. The decided bit enters bit 0 of a 16-bit shift register, and the older bits move up by one place.

The block runs on an oversampling system clock. The wire first passes through a two-flop synchroniser. Low pulses shorter than two clocks count as noise and are dropped. The low-time counter saturates, so a low of any length decodes as 0.

When the line has stayed high for a set number of clocks after at least one new bit, the block copies the shift register into a parallel output register. It marks that copy with a one-clock valid strobe. The sender therefore closes a word simply by going quiet.

Top module: `pwsw_rx`

## Requirements
- R1: On each accepted rising edge of `line_i`, the new bit enters bit 0 of the 16-bit shift register and every other bit moves up one place, toward bit 15. Only the latest 16 bits are kept.
- R2: A low time L, counted in clocks of `line_i` held low, with 2 <= L < LOW_THRESH (default 8), shifts in a 1.
- R3: A low time L >= LOW_THRESH shifts in a 0. This includes lows far longer than the counter range, because the counter saturates.
- R4: A low pulse of fewer than 2 clocks is ignored. The shift register does not change, and a following word shows no trace of the pulse.
- R5: After `line_i` has been high for IDLE_CLKS (default 64) clocks following an accepted bit, `data_o` takes the shift register contents and `valid_o` is high for exactly one clock. The strobe first reads high IDLE_CLKS+2 clock edges after the first edge that samples `line_i` high.
- R6: No further strobe occurs until at least one new bit has been accepted, however long the line stays idle.
- R7: The active-low asynchronous reset `rst_ni` clears the shift register, `data_o`, `valid_o` and the counters. The line state is taken as idle high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Asynchronous single-wire serial line, idle high |
| data_o | output | 16 | Parallel word, updated at each strobe |
| valid_o | output | 1 | One-clock strobe marking a new `data_o` |

## Verification
A rising edge on the wire reaches the decoder through two synchroniser flops and one edge-detect flop. The shift register therefore updates two edges after the first edge that samples `line_i` high. The strobe follows IDLE_CLKS edges later, at edge IDLE_CLKS+2. The driver task counts clock edges from the moment it releases the line after the last bit of a word. It samples `valid_o` on the falling edge one cycle before the due edge, expecting low, and on the falling edge just after it, expecting high. The monitor process pops the expected word whenever it sees `valid_o` high. Any strobe that arrives with no word queued is reported as a spurious latch.

// File: rtl/pwsw_pkg.sv
package pwsw_pkg;
  typedef struct packed {
    logic vld;
    logic val;
  } bit_evt_t;
endpackage

// File: rtl/pwsw_sync.sv
module pwsw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;  // idle high
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/pwsw_lowtimer.sv
module pwsw_lowtimer
  import pwsw_pkg::*;
#(
  parameter int LOW_THRESH = 8,
  parameter int MIN_LOW    = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     line_s_i,
  output bit_evt_t evt_o,
  output logic     glitch_o
);
  localparam int LW = $clog2(LOW_THRESH + 1);
  localparam logic [LW-1:0] CNT_SAT = LW'(LOW_THRESH);
  localparam logic [LW-1:0] CNT_MIN = LW'(MIN_LOW);

  logic          line_q;
  logic [LW-1:0] cnt_q;
  logic          rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b1;
    else         line_q <= line_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (line_s_i)                   cnt_q <= '0;
    else if (cnt_q != CNT_SAT)           cnt_q <= cnt_q + 1'b1;
  end

  assign rise      = line_s_i & ~line_q;
  assign evt_o.vld = rise && (cnt_q >= CNT_MIN);
  assign evt_o.val = (cnt_q < CNT_SAT);
  assign glitch_o  = rise && (cnt_q < CNT_MIN);

  AST_LOW_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_s_i && cnt_q == CNT_SAT) |=> (cnt_q == CNT_SAT)); // R3
  AST_CNT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_s_i |=> (cnt_q == '0)); // R1
endmodule

// File: rtl/pwsw_frame.sv
module pwsw_frame
  import pwsw_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int IDLE_CLKS = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_s_i,
  input  bit_evt_t         evt_i,
  output logic [WIDTH-1:0] shreg_o,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o
);
  localparam int IW = $clog2(IDLE_CLKS + 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CLKS - 1);

  logic [WIDTH-1:0] sh_q;
  logic [WIDTH-1:0] out_q;
  logic [IW-1:0]    idle_q;
  logic             pend_q;
  logic             vld_q;
  logic             fire;

  assign fire = pend_q && line_s_i && !evt_i.vld && (idle_q == IDLE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sh_q <= '0;
    else if (evt_i.vld) sh_q <= {sh_q[WIDTH-2:0], evt_i.val};
  end

  // idle time counts only while a word is open
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 idle_q <= '0;
    else if (!line_s_i || evt_i.vld || !pend_q)  idle_q <= '0;
    else if (!fire)                              idle_q <= idle_q + 1'b1;
    else                                         idle_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (evt_i.vld) pend_q <= 1'b1;
    else if (fire)      pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= fire;
      if (fire) out_q <= sh_q;
    end
  end

  assign shreg_o = sh_q;
  assign data_o  = out_q;
  assign valid_o = vld_q;

  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.vld |=> (sh_q == {$past(sh_q[WIDTH-2:0]), $past(evt_i.val)})); // R1
  AST_STROBE_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R5
  AST_LATCH_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (data_o == $past(sh_q))); // R5
  AST_NO_RELATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !evt_i.vld) |=> !valid_o ##1 !valid_o); // R6
endmodule

// File: rtl/pwsw_rx.sv
module pwsw_rx
  import pwsw_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int LOW_THRESH = 8,
  parameter int MIN_LOW    = 2,
  parameter int IDLE_CLKS  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o
);
  logic             line_s;
  bit_evt_t         evt;
  logic             glitch;
  logic [WIDTH-1:0] shreg;

  pwsw_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  pwsw_lowtimer #(
    .LOW_THRESH(LOW_THRESH),
    .MIN_LOW   (MIN_LOW)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_s_i(line_s),
    .evt_o   (evt),
    .glitch_o(glitch)
  );

  pwsw_frame #(
    .WIDTH    (WIDTH),
    .IDLE_CLKS(IDLE_CLKS)
  ) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_s_i(line_s),
    .evt_i   (evt),
    .shreg_o (shreg),
    .data_o  (data_o),
    .valid_o (valid_o)
  );

  AST_GLITCH_NO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glitch |=> $stable(shreg)); // R4
  AST_NO_STROBE_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_s |=> !valid_o); // R5
endmodule

// File: tb/pwsw_rx_test.sv
module pwsw_rx_test;
  localparam int W      = 16;
  localparam int THRESH = 8;
  localparam int IDLE   = 64;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         line_i = 1'b1;
  logic [W-1:0] data_o;
  logic         valid_o;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] model = '0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  pwsw_rx #(.WIDTH(W), .LOW_THRESH(THRESH), .MIN_LOW(2), .IDLE_CLKS(IDLE)) uut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .data_o (data_o),
    .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // low for L clocks, then release; 3 idle clocks follow
  task automatic send_bit(input int len);
    @(negedge clk) line_i = 1'b0;
    repeat (len) @(negedge clk);
    line_i = 1'b1;
    if (len >= 2) model = {model[W-2:0], (len < THRESH) ? 1'b1 : 1'b0};
    repeat (3) @(negedge clk);
  endtask

  task automatic send_word(input logic [W-1:0] w, input int n, input int l1, input int l0);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i] ? l1 : l0);
  endtask

  // called right after the last send_bit; checks strobe timing
  task automatic end_burst(input string tag);
    exp_q.push_back(model);
    tag_q.push_back(tag);
    repeat (IDLE - 1) @(negedge clk);
    chk(valid_o == 1'b0, "R5", "strobe early", {31'b0, valid_o}, 32'h0);
    @(negedge clk);
    chk(valid_o == 1'b1, "R5", "strobe due", {31'b0, valid_o}, 32'h1);
    @(negedge clk);
    chk(valid_o == 1'b0, "R5", "strobe width", {31'b0, valid_o}, 32'h0);
  endtask

  // monitor: compare each strobe against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6", "spurious strobe", {16'b0, data_o}, 32'h0);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(data_o == e, t, "word", {16'b0, data_o}, {16'b0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(data_o == '0, "R7", "reset data", {16'b0, data_o}, 32'h0);
    chk(valid_o == 1'b0, "R7", "reset valid", {31'b0, valid_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R7: 4 bits after reset leave upper bits zero
    send_word(16'h000B, 4, 3, 12);
    end_burst("R7");

    // R1/R2/R3: full word, nominal widths
    send_word(16'hA5C3, 16, 3, 12);
    end_burst("R1");

    // R2/R3 boundaries: 1 at L=2 and L=7, 0 at L=8
    send_bit(2); send_bit(7); send_bit(8); send_bit(7);
    send_bit(8); send_bit(8); send_bit(2); send_bit(7);
    end_burst("R2");

    // R3: saturating long lows decode as 0
    send_bit(3); send_bit(40); send_bit(3); send_bit(100);
    end_burst("R3");

    // R4: 1-clock glitches between real bits leave no trace
    send_bit(3); send_bit(1); send_bit(12); send_bit(1);
    send_bit(1); send_bit(3); send_bit(12);
    end_burst("R4");

    // R6: long quiet line, no second strobe (monitor flags any)
    repeat (3 * IDLE) @(negedge clk);
    chk(valid_o == 1'b0, "R6", "idle no strobe", {31'b0, valid_o}, 32'h0);

    // R4: a lone glitch opens no new word
    send_bit(1);
    repeat (2 * IDLE) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "queue drained", exp_q.size(), 32'h0);

    // R1: more than 16 bits keep only the latest 16
    send_word(16'h3C96, 16, 4, 9);
    send_word(16'h0005, 3, 4, 9);
    end_burst("R1");

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "all words seen", exp_q.size(), 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule